// File: doc/BRIEF.md
# I2C Bus Timing Monitor

This block is a passive observer of a two-wire I2C bus. It never drives SCL or SDA. Both lines are brought into the system clock domain through a two-flop synchroniser. The block then finds bus START and STOP conditions and times the intervals between line edges by counting system-clock cycles. Any interval shorter than the bus minimum sets a sticky flag. There is one flag per timing rule, so a bring-up bench or a running chip can tell which rule a remote device broke.

There are two sets of limits, standard mode and fast mode. A single input picks between them. A parameter holds the system clock period in nanoseconds, and every limit in nanoseconds is turned into a cycle count by rounding up. Each detected START and STOP also gives a one-cycle pulse, which other logic can use to frame transfers.

Top module: `i2c_bus_timing_mon`

## Requirements
- R1: A START is SDA going 1→0 while SCL is high, and a STOP is SDA going 0→1 while SCL is high. Each one drives `start_pulse` or `stop_pulse` high for exactly one cycle. The pulse is high after the third rising clock edge that follows the SDA change at the pins.
- R2: An SDA change counts as a START or STOP only when SCL is high in both the current synchronised sample and the previous one. An SDA change in the same cycle as an SCL edge, including a data hold time of zero after SCL falls, gives no pulse and no flag.
- R3: Flag bit 0 (`viol_low`) is set when SCL stays low for fewer cycles than the low-width limit. This rule is armed only by the first START after reset, so SCL low pulses before that START are never flagged.
- R4: Flag bit 1 (`viol_high`) is set when SCL stays high for fewer cycles than the high-width limit. The width is measured at the SCL falling edge.
- R5: Flag bit 2 (`viol_su_start`) is set when a START follows the last SCL rising edge by fewer cycles than the START setup limit.
- R6: Flag bit 3 (`viol_su_stop`) is set when a STOP follows the last SCL rising edge by fewer cycles than the STOP setup limit.
- R7: Flag bit 4 (`viol_bus_free`) is set when a START follows the last STOP by fewer cycles than the bus-free limit. This rule is checked only when a STOP has been seen since the previous START, or since reset.
- R8: The limits are ceil(ns / CLK_PERIOD_NS) cycles. With `fast_mode`=0 the values in ns are: low 4700, high 4000, START setup 4700, STOP setup 4000, bus free 4700. With `fast_mode`=1 they are: low 1300, high 600, START setup 1300, STOP setup 600, bus free 1300. An interval of exactly the limit is legal. The limit set used is the one selected in the cycle the interval ends.
- R9: A flag rises on the same clock edge as the pulse for the event that closed the short interval. It then stays set until `clear` is high at a clock edge, which zeroes all flags. If `clear` and a new violation arrive in the same cycle, `clear` wins.
- R10: Interval counters saturate at 2^CNT_W−1 and do not wrap. Reset loads them saturated, so idle time of any length, or no history at all, never reads as a short interval.
- R11: While `rst` is high and in the first cycle after it, all flags and both pulses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Observed SCL line level (asynchronous) |
| sda_in | input | 1 | Observed SDA line level (asynchronous) |
| fast_mode | input | 1 | 0 selects standard-mode limits, 1 selects fast-mode limits |
| clear | input | 1 | Synchronous clear of all violation flags |
| start_pulse | output | 1 | One-cycle pulse per detected START |
| stop_pulse | output | 1 | One-cycle pulse per detected STOP |
| viol_low | output | 1 | Sticky: SCL low width too short |
| viol_high | output | 1 | Sticky: SCL high width too short |
| viol_su_start | output | 1 | Sticky: START setup too short |
| viol_su_stop | output | 1 | Sticky: STOP setup too short |
| viol_bus_free | output | 1 | Sticky: STOP-to-START bus free too short |

## Verification
The bench builds the monitor with CLK_PERIOD_NS=100 and CNT_W=8. The limits then shrink to between 6 and 47 cycles, so every rule can be tested one cycle under and exactly at its limit, in both modes, within a short run. The 8-bit counter saturates at 255, which puts an SCL low phase longer than the counter range within reach. A wrapping counter would misread that phase as short.

// File: rtl/i2cmon_pkg.sv
package i2cmon_pkg;

    localparam int NRULE = 5;

    // Rule index doubles as the flag bit position.
    typedef enum logic [2:0] {
        RULE_LOW    = 3'd0,
        RULE_HIGH   = 3'd1,
        RULE_SU_STA = 3'd2,
        RULE_SU_STO = 3'd3,
        RULE_FREE   = 3'd4
    } rule_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    // Minimum interval in ns for one rule in one mode.
    function automatic int unsigned limit_ns(input bit fast, input int rule);
        int unsigned v;
        case (rule)
            RULE_LOW:    v = fast ? 1300 : 4700;
            RULE_HIGH:   v = fast ?  600 : 4000;
            RULE_SU_STA: v = fast ? 1300 : 4700;
            RULE_SU_STO: v = fast ?  600 : 4000;
            default:     v = fast ? 1300 : 4700;
        endcase
        return v;
    endfunction

    // Round up so that a count equal to the limit always meets the ns minimum.
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned period);
        return (ns + period - 1) / period;
    endfunction

endpackage

// File: rtl/i2cmon_sync.sv
module i2cmon_sync #(
    parameter int          W       = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/i2cmon_age.sv
module i2cmon_age #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         restart,
    output logic [W-1:0] age
);
    localparam logic [W-1:0] AGE_MAX = '1;

    // Holds the number of samples since the last restart, saturating.
    always_ff @(posedge clk) begin
        if (rst)
            age <= AGE_MAX;
        else if (restart)
            age <= W'(1);
        else if (age != AGE_MAX)
            age <= age + W'(1);
    end
endmodule

// File: rtl/i2cmon_rules.sv
module i2cmon_rules
    import i2cmon_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 5,
    parameter int CNT_W         = 12
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             clear,
    input  logic                             fast,
    input  logic [NRULE-1:0]                 ev,
    input  logic [NRULE-1:0][CNT_W-1:0]      meas,
    output logic [NRULE-1:0]                 flag
);
    logic [NRULE-1:0] hit;

    for (genvar r = 0; r < NRULE; r++) begin : g_rule
        localparam logic [CNT_W-1:0] LIM_STD  =
            CNT_W'(ns_to_cyc(limit_ns(1'b0, r), CLK_PERIOD_NS));
        localparam logic [CNT_W-1:0] LIM_FAST =
            CNT_W'(ns_to_cyc(limit_ns(1'b1, r), CLK_PERIOD_NS));

        assign hit[r] = ev[r] && (meas[r] < (fast ? LIM_FAST : LIM_STD));
    end

    always_ff @(posedge clk) begin
        if (rst || clear)
            flag <= '0;
        else
            flag <= flag | hit;
    end
endmodule

// File: rtl/i2c_bus_timing_mon.sv
module i2c_bus_timing_mon
    import i2cmon_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 5,
    parameter int CNT_W         = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_in,
    input  logic sda_in,
    input  logic fast_mode,
    input  logic clear,
    output logic start_pulse,
    output logic stop_pulse,
    output logic viol_low,
    output logic viol_high,
    output logic viol_su_start,
    output logic viol_su_stop,
    output logic viol_bus_free
);
    logic                        scl_s, sda_s, scl_p, sda_p;
    bus_ev_t                     ev;
    logic                        armed, stop_seen;
    logic [CNT_W-1:0]            edge_age, free_age;
    logic [NRULE-1:0]            rule_ev;
    logic [NRULE-1:0][CNT_W-1:0] rule_meas;
    logic [NRULE-1:0]            flags;

    i2cmon_sync #(.W(2), .RST_VAL(2'b11)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({scl_in, sda_in}),
        .q   ({scl_s, sda_s})
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    always_comb begin
        ev.scl_rise = scl_s && !scl_p;
        ev.scl_fall = !scl_s && scl_p;
        ev.start    = scl_s && scl_p && sda_p && !sda_s;
        ev.stop     = scl_s && scl_p && !sda_p && sda_s;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed     <= 1'b0;
            stop_seen <= 1'b0;
        end else begin
            if (ev.start)
                armed <= 1'b1;
            if (ev.stop)
                stop_seen <= 1'b1;
            else if (ev.start)
                stop_seen <= 1'b0;
        end
    end

    i2cmon_age #(.W(CNT_W)) u_edge_age (
        .clk     (clk),
        .rst     (rst),
        .restart (ev.scl_rise || ev.scl_fall),
        .age     (edge_age)
    );

    i2cmon_age #(.W(CNT_W)) u_free_age (
        .clk     (clk),
        .rst     (rst),
        .restart (ev.stop),
        .age     (free_age)
    );

    always_comb begin
        rule_ev[RULE_LOW]      = ev.scl_rise && armed;
        rule_ev[RULE_HIGH]     = ev.scl_fall;
        rule_ev[RULE_SU_STA]   = ev.start;
        rule_ev[RULE_SU_STO]   = ev.stop;
        rule_ev[RULE_FREE]     = ev.start && stop_seen;
        rule_meas[RULE_LOW]    = edge_age;
        rule_meas[RULE_HIGH]   = edge_age;
        rule_meas[RULE_SU_STA] = edge_age;
        rule_meas[RULE_SU_STO] = edge_age;
        rule_meas[RULE_FREE]   = free_age;
    end

    i2cmon_rules #(.CLK_PERIOD_NS(CLK_PERIOD_NS), .CNT_W(CNT_W)) u_rules (
        .clk   (clk),
        .rst   (rst),
        .clear (clear),
        .fast  (fast_mode),
        .ev    (rule_ev),
        .meas  (rule_meas),
        .flag  (flags)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            start_pulse <= 1'b0;
            stop_pulse  <= 1'b0;
        end else begin
            start_pulse <= ev.start;
            stop_pulse  <= ev.stop;
        end
    end

    assign viol_low      = flags[RULE_LOW];
    assign viol_high     = flags[RULE_HIGH];
    assign viol_su_start = flags[RULE_SU_STA];
    assign viol_su_stop  = flags[RULE_SU_STO];
    assign viol_bus_free = flags[RULE_FREE];
endmodule

// File: rtl/i2cmon_checker.sv
module i2cmon_checker (
    input logic       clk,
    input logic       rst,
    input logic       clear,
    input logic       start_pulse,
    input logic       stop_pulse,
    input logic [4:0] viol
);
    // R1: a START and a STOP are never reported in the same cycle
    a_r1_pulse_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(start_pulse && stop_pulse));

    // R1: each pulse lasts one cycle
    a_r1_start_single: assert property (@(posedge clk) disable iff (rst)
        start_pulse |=> !start_pulse);
    a_r1_stop_single: assert property (@(posedge clk) disable iff (rst)
        stop_pulse |=> !stop_pulse);

    // R5: START setup flag rises together with a START pulse
    a_r5_sta_with_start: assert property (@(posedge clk) disable iff (rst)
        $rose(viol[2]) |-> start_pulse);

    // R6: STOP setup flag rises together with a STOP pulse
    a_r6_sto_with_stop: assert property (@(posedge clk) disable iff (rst)
        $rose(viol[3]) |-> stop_pulse);

    // R7: bus free flag rises together with a START pulse
    a_r7_free_with_start: assert property (@(posedge clk) disable iff (rst)
        $rose(viol[4]) |-> start_pulse);

    // R9: flags never drop without clear, and clear empties them
    a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
        !clear |=> ((viol & $past(viol)) == $past(viol)));
    a_r9_clear: assert property (@(posedge clk) disable iff (rst)
        clear |=> (viol == 5'b0));
endmodule

bind i2c_bus_timing_mon i2cmon_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .clear       (clear),
    .start_pulse (start_pulse),
    .stop_pulse  (stop_pulse),
    .viol        ({viol_bus_free, viol_su_stop, viol_su_start, viol_high, viol_low})
);

// File: tb/i2c_bus_timing_mon_test.sv
`timescale 1ns/1ps
module i2c_bus_timing_mon_test;
    localparam int PER = 100;
    localparam int CW  = 8;
    localparam int NV  = 21;

    // {fast[17], rule[16:14], duration[13:5], expected flags[4:0]}
    localparam logic [17:0] TBL [NV] = '{
        {1'b0, 3'd0, 9'd46,  5'b00001}, {1'b0, 3'd0, 9'd47,  5'b00000},
        {1'b1, 3'd0, 9'd12,  5'b00001}, {1'b1, 3'd0, 9'd13,  5'b00000},
        {1'b0, 3'd1, 9'd39,  5'b00010}, {1'b0, 3'd1, 9'd40,  5'b00000},
        {1'b1, 3'd1, 9'd5,   5'b00010}, {1'b1, 3'd1, 9'd6,   5'b00000},
        {1'b0, 3'd2, 9'd46,  5'b00100}, {1'b0, 3'd2, 9'd47,  5'b00000},
        {1'b1, 3'd2, 9'd12,  5'b00100}, {1'b1, 3'd2, 9'd13,  5'b00000},
        {1'b0, 3'd3, 9'd39,  5'b01000}, {1'b0, 3'd3, 9'd40,  5'b00000},
        {1'b1, 3'd3, 9'd5,   5'b01000}, {1'b1, 3'd3, 9'd6,   5'b00000},
        {1'b0, 3'd4, 9'd46,  5'b10000}, {1'b0, 3'd4, 9'd47,  5'b00000},
        {1'b1, 3'd4, 9'd12,  5'b10000}, {1'b1, 3'd4, 9'd13,  5'b00000},
        {1'b0, 3'd0, 9'd300, 5'b00000}
    };

    logic clk = 1'b0, rst = 1'b1, scl = 1'b1, sda = 1'b1, fast = 1'b0, clr = 1'b0;
    logic start_pulse, stop_pulse, v_low, v_high, v_sta, v_sto, v_free;
    logic [4:0] viol;
    int total = 0, bad = 0, n_sta = 0, n_sto = 0;

    assign viol = {v_free, v_sto, v_sta, v_high, v_low};

    i2c_bus_timing_mon #(.CLK_PERIOD_NS(PER), .CNT_W(CW)) uut (
        .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda), .fast_mode(fast),
        .clear(clr), .start_pulse(start_pulse), .stop_pulse(stop_pulse),
        .viol_low(v_low), .viol_high(v_high), .viol_su_start(v_sta),
        .viol_su_stop(v_sto), .viol_bus_free(v_free)
    );

    always #2.5 clk = ~clk;

    always @(negedge clk) begin
        if (start_pulse) n_sta++;
        if (stop_pulse)  n_sto++;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Called at a negedge; the levels stay for n sampling edges.
    task automatic hold(input logic c, input logic d, input int n);
        scl = c;
        sda = d;
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1; scl = 1'b1; sda = 1'b1; clr = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic do_clear();
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    task automatic scenario(input int rule, input int n);
        case (rule)
            0: begin
                hold(1,1,60); hold(1,0,60); hold(0,0,n); hold(1,0,60); hold(1,1,60);
            end
            1: begin
                hold(1,1,60); hold(1,0,60); hold(0,0,60); hold(1,0,n);
                hold(0,0,60); hold(1,0,60); hold(1,1,60);
            end
            2: begin
                hold(1,1,60); hold(1,0,60); hold(0,0,60); hold(0,1,60); hold(1,1,n);
                hold(1,0,60); hold(0,0,60); hold(1,0,60); hold(1,1,60);
            end
            3: begin
                hold(1,1,60); hold(1,0,60); hold(0,0,60); hold(1,0,n); hold(1,1,60);
            end
            default: begin
                hold(1,1,60); hold(1,0,60); hold(0,0,60); hold(1,0,60); hold(1,1,n);
                hold(1,0,60); hold(0,0,60); hold(1,0,60); hold(1,1,60);
            end
        endcase
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        int s0, p0;
        @(negedge clk);
        do_reset();
        // R11: reset state
        check("R11 flags after reset", 32'(viol), 0);
        check("R11 pulses after reset", 32'({start_pulse, stop_pulse}), 0);

        // R10 R7: START 3 cycles after reset, with saturated counters and no STOP seen
        s0 = n_sta;
        hold(1,1,3); hold(1,0,60); hold(0,0,60); hold(1,0,60); hold(1,1,60);
        check("R10 R7 early start no flags", 32'(viol), 0);
        check("R1 one start counted", 32'(n_sta - s0), 1);

        // R3: short SCL low before any START after reset is ignored
        do_reset();
        hold(1,1,5); hold(0,1,5); hold(1,1,60);
        check("R3 unarmed low width", 32'(viol), 0);

        // R1: pulse timing after the SDA fall
        scl = 1'b1; sda = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 no pulse after two edges", 32'(start_pulse), 0);
        @(negedge clk);
        check("R1 pulse after third edge", 32'(start_pulse), 1);
        @(negedge clk);
        check("R1 pulse one cycle", 32'(start_pulse), 0);
        hold(1,0,60); hold(0,0,60); hold(1,0,60); hold(1,1,60);

        // R2: SDA changes together with SCL edges are not START or STOP
        do_clear();
        hold(1,0,60);
        s0 = n_sta; p0 = n_sto;
        hold(0,1,60); hold(1,0,60); hold(0,0,60);
        check("R2 no start on coincident edge", 32'(n_sta - s0), 0);
        check("R2 no stop on zero hold", 32'(n_sto - p0), 0);
        hold(1,0,60); hold(1,1,60);
        check("R2 no flags", 32'(viol), 0);

        // R3-R8, R10: vector table
        for (int i = 0; i < NV; i++) begin
            do_clear();
            fast = TBL[i][17];
            scenario(int'(TBL[i][16:14]), int'(TBL[i][13:5]));
            check($sformatf("R8 vec%0d rule%0d dur%0d (R3 R4 R5 R6 R7 R10)", i,
                  TBL[i][16:14], TBL[i][13:5]), 32'(viol), 32'(TBL[i][4:0]));
        end

        // R8: mode switched mid low phase, limit taken when the phase ends
        do_clear();
        fast = 1'b0;
        hold(1,1,60); hold(1,0,60); hold(0,0,10);
        fast = 1'b1;
        hold(0,0,10); hold(1,0,60); hold(1,1,60);
        check("R8 switch to fast mid low", 32'(viol), 0);
        do_clear();
        hold(1,1,60); hold(1,0,60); hold(0,0,10);
        fast = 1'b0;
        hold(0,0,10); hold(1,0,60); hold(1,1,60);
        check("R8 switch to standard mid low", 32'(viol), 1);

        // R9: flag persists through legal traffic, then clear removes it
        scenario(3, 60);
        check("R9 sticky", 32'(viol), 1);
        do_clear();
        check("R9 clear", 32'(viol), 0);

        finish_run();
    end
endmodule